// File: doc/BRIEF.md
# Serial Command Receiver with Chain Pass-Through and Register Readback

This block receives 24-bit command frames on a four-wire serial link (frame select `sync_n`, serial clock `sclk`, data in `din`, data out `sdo`) and turns each complete frame into one decoded command for a register bank. All four link pins are asynchronous to the system clock `clk`. They are brought in through synchronizer stages, and every action is taken on edges detected in the `clk` domain. A frame opens when `sync_n` falls. Bits enter MSB first on falling `sclk` edges, and the frame is accepted when `sync_n` rises. `sdo` changes only on rising `sclk` edges or when a frame opens, so the master samples it on the falling edge.

With `chain_en` low the device stands alone and takes exactly 24 bits per frame. With `chain_en` high, extra bits keep shifting through, so `sdo` can feed the `din` of the next device in a chain. A frame whose read flag is set loads the addressed register's value, which the bank returns on `rd_data`, together with the frame's upper ten bits. That word is shifted out on `sdo` during the following frame.

The decoded command leaves on a valid-only stream. `cmd_valid` is high for one `clk` cycle and has no back-pressure, so the sink must accept every pulse. In the cycle `cmd_valid` is high with `cmd_rw` set, the bank must drive `rd_data` combinationally from `cmd_chan` and `cmd_sel`.

Timing limits for the link:
- Each `sclk` phase must last at least SYNC_STAGES+2 `clk` cycles.
- `sync_n` must stay high for at least SYNC_STAGES+3 cycles between frames.
- `din` must not change near a falling `sclk` edge.

Top module: `serial_cmd_rx`

## Requirements
- R1: While reset is asserted and right after it, `sdo` is 0 and `cmd_valid` is 0.
- R2: A frame that has received exactly 24 bits when `sync_n` rises produces exactly one single-cycle `cmd_valid` pulse. The frame is MSB first. Bit 22 drives `cmd_rw`, bits 20:16 drive `cmd_chan`, bits 15:14 drive `cmd_sel` and bits 13:0 drive `cmd_data`. Bits 23 and 21 are zero in valid frames.
- R3: A falling `sync_n` restarts the bit count, so a complete frame that follows an aborted one decodes correctly.
- R4: If `sync_n` rises after fewer than 24 falling `sclk` edges, in either mode, the frame is discarded and no `cmd_valid` pulse appears.
- R5: With `chain_en` low, `sclk` edges after the 24th bit are ignored until the next frame. The decoded command is the first 24 bits, and `sdo` holds still during those extra edges.
- R6: With `chain_en` high, bits beyond 24 keep shifting. `sdo` presents the bit received 24 falling edges earlier, and the decoded command is the last 24 bits of the frame.
- R7: `sdo` changes only after a rising `sclk` edge or a falling `sync_n`. It never changes during the low phase of `sclk`.
- R8: After a frame with `cmd_rw`=1 (for example 0x404ABC reads channel 0, register select 01), the next frame shifts out on `sdo`, MSB first, the 10 upper bits of that read frame followed by the 14-bit `rd_data` value the bank returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_en | input | 1 | 1 = chain pass-through, 0 = standalone 24-bit frames |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in, sampled on falling sclk |
| sdo | output | 1 | Serial data out, updated on rising sclk |
| cmd_valid | output | 1 | One-cycle command pulse, no back-pressure |
| cmd_rw | output | 1 | Read flag of the command |
| cmd_chan | output | 5 | Channel address |
| cmd_sel | output | 2 | Register select |
| cmd_data | output | 14 | Data field |
| rd_data | input | 14 | Register value for a read command, valid while cmd_valid |

## Verification
The bench builds the block with SYNC_STAGES=2 and the 24-bit layout. It drives `sclk` with 8-cycle phases, which leaves a margin of several cycles over the synchronizer delay. This makes one-bit differences in the edge timing of `sdo` visible at the master's sample point. The two-stage depth also lets frames of 10, 20, 24, 30 and 48 bits run within a short run, which covers discard, overrun in standalone mode and a full two-device chain pass. Readback is exercised twice, including the 0x404ABC case, against a bank model the bench computes.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int FRAME_BITS = 24;
  localparam int DATA_W     = 14;
  localparam int SEL_W      = 2;
  localparam int CHAN_W     = 5;
  localparam int SEL_LO     = DATA_W;
  localparam int CHAN_LO    = SEL_LO + SEL_W;
  localparam int RW_POS     = FRAME_BITS - 2;
  localparam int HDR_W      = FRAME_BITS - DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic              rw;
    logic [CHAN_W-1:0] chan;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/scr_sync_bit.sv
module scr_sync_bit #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{INIT}};
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/scr_sync_edge.sv
module scr_sync_edge #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic rise,
  output logic fall
);
  logic lvl, prev;

  scr_sync_bit #(.STAGES(STAGES), .INIT(INIT)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= INIT;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/scr_shift_core.sv
module scr_shift_core
  import scr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chain_en,
  input  logic                  start,
  input  logic                  stop,
  input  logic                  sclk_rise,
  input  logic                  sclk_fall,
  input  logic                  din_s,
  input  logic                  load_en,
  input  logic [FRAME_BITS-1:0] load_val,
  output logic [FRAME_BITS-1:0] sr,
  output logic                  full,
  output logic                  sdo
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             accept;

  assign full   = (cnt == CNT_MAX);
  assign accept = active & (chain_en | ~full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sr     <= '0;
      sdo    <= 1'b0;
      active <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      active <= 1'b1;
      sdo    <= sr[FRAME_BITS-1];
    end else if (stop) begin
      active <= 1'b0;
    end else if (load_en) begin
      sr <= load_val;
    end else begin
      if (accept && sclk_fall) begin
        sr <= {sr[FRAME_BITS-2:0], din_s};
        if (!full) cnt <= cnt + 1'b1;
      end
      if (accept && sclk_rise) sdo <= sr[FRAME_BITS-1];
    end
  end

  // restart of the count on every frame opening
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);

  // standalone overrun: nothing moves once 24 bits are in
  assert_overrun_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_en && full && active && !start && !stop && !load_en)
      |=> ($stable(sr) && $stable(sdo)));

  // chain mode keeps shifting the newest bit in at the bottom
  assert_chain_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && active && sclk_fall && !start && !stop && !load_en)
      |=> (sr[0] == $past(din_s)));

  assert_sdo_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo != $past(sdo)) |-> $past(start || sclk_rise));
endmodule

// File: rtl/scr_cmd_decode.sv
module scr_cmd_decode
  import scr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stop,
  input  logic                  full,
  input  logic [FRAME_BITS-1:0] sr,
  input  logic [DATA_W-1:0]     rd_data,
  output logic                  cmd_valid,
  output cmd_t                  cmd,
  output logic                  load_en,
  output logic [FRAME_BITS-1:0] load_val
);
  logic [HDR_W-1:0] hdr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd       <= '0;
      hdr       <= '0;
    end else begin
      cmd_valid <= stop & full;
      if (stop && full) begin
        cmd.rw   <= sr[RW_POS];
        cmd.chan <= sr[CHAN_LO +: CHAN_W];
        cmd.sel  <= sr[SEL_LO +: SEL_W];
        cmd.data <= sr[DATA_W-1:0];
        hdr      <= sr[FRAME_BITS-1 -: HDR_W];
      end
    end
  end

  assign load_en  = cmd_valid & cmd.rw;
  assign load_val = {hdr, rd_data};

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_short_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !full) |=> !cmd_valid);
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import scr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_en,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              din,
  output logic              sdo,
  output logic              cmd_valid,
  output logic              cmd_rw,
  output logic [CHAN_W-1:0] cmd_chan,
  output logic [SEL_W-1:0]  cmd_sel,
  output logic [DATA_W-1:0] cmd_data,
  input  logic [DATA_W-1:0] rd_data
);
  logic                  sync_rise, sync_fall;
  logic                  sclk_rise, sclk_fall;
  logic                  din_s;
  logic [FRAME_BITS-1:0] sr;
  logic                  full;
  logic                  load_en;
  logic [FRAME_BITS-1:0] load_val;
  cmd_t                  cmd;

  scr_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_edge (
    .clk(clk), .rst_n(rst_n), .raw(sync_n), .rise(sync_rise), .fall(sync_fall)
  );

  scr_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .raw(sclk), .rise(sclk_rise), .fall(sclk_fall)
  );

  // same depth as the edge path so data lines up with the detected edge
  scr_sync_bit #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_din_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
  );

  scr_shift_core u_core (
    .clk(clk), .rst_n(rst_n), .chain_en(chain_en),
    .start(sync_fall), .stop(sync_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din_s(din_s),
    .load_en(load_en), .load_val(load_val),
    .sr(sr), .full(full), .sdo(sdo)
  );

  scr_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .stop(sync_rise), .full(full), .sr(sr),
    .rd_data(rd_data), .cmd_valid(cmd_valid), .cmd(cmd),
    .load_en(load_en), .load_val(load_val)
  );

  assign cmd_rw   = cmd.rw;
  assign cmd_chan = cmd.chan;
  assign cmd_sel  = cmd.sel;
  assign cmd_data = cmd.data;

  assert_valid_after_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(sync_rise));

  assert_readback_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (sr == $past(load_val)));
endmodule

// File: tb/sim_serial_cmd_rx.sv
module sim_serial_cmd_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chain_en = 1'b0;
  logic sync_n = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic sdo, cmd_valid, cmd_rw;
  logic [4:0]  cmd_chan;
  logic [1:0]  cmd_sel;
  logic [13:0] cmd_data;
  logic [13:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [23:0] got_q[$];
  logic prev_valid = 1'b0;
  logic [63:0] so_bits;
  bit low_ok;

  always #4 clk = ~clk;

  function automatic logic [13:0] bank_val(input logic [4:0] c, input logic [1:0] s);
    int v;
    v = int'(c) * 211 + int'(s) * 1301 + 77;
    return v[13:0];
  endfunction

  assign rd_data = bank_val(cmd_chan, cmd_sel);

  serial_cmd_rx u0 (
    .clk(clk), .rst_n(rst_n), .chain_en(chain_en), .sync_n(sync_n),
    .sclk(sclk), .din(din), .sdo(sdo), .cmd_valid(cmd_valid),
    .cmd_rw(cmd_rw), .cmd_chan(cmd_chan), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input bit rw, input logic [4:0] c,
                                     input logic [1:0] s, input logic [13:0] d);
    return {1'b0, rw, 1'b0, c, s, d};
  endfunction

  // per-clock reference: pulses are single cycle, each one is a decoded frame
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(cmd_valid && prev_valid), "R2", "cmd_valid longer than one cycle",
          64'(cmd_valid), 64'd0);
      if (cmd_valid) got_q.push_back(mk(cmd_rw, cmd_chan, cmd_sel, cmd_data));
    end
    prev_valid = cmd_valid;
  end

  task automatic send(input int n, input logic [63:0] bits);
    logic s;
    so_bits = '0;
    low_ok = 1'b1;
    sync_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      sclk = 1'b1;
      din = bits[n-1-k];
      repeat (8) @(negedge clk);
      s = sdo;
      so_bits[n-1-k] = s;
      sclk = 1'b0;
      repeat (8) @(negedge clk);
      if (sdo !== s) low_ok = 1'b0;
    end
    sync_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic expect_cmd(input logic [23:0] exp, input string req);
    chk(got_q.size() == 1, req, "command count", 64'(got_q.size()), 64'd1);
    if (got_q.size() >= 1) chk(got_q[0] == exp, req, "decoded frame", 64'(got_q[0]), 64'(exp));
    got_q.delete();
  endtask

  task automatic expect_none(input string req);
    chk(got_q.size() == 0, req, "discarded frame produced command", 64'(got_q.size()), 64'd0);
    got_q.delete();
  endtask

  initial begin
    logic [23:0] fa, fb, fc, fx, fy, fr;
    bit ok;
    repeat (5) @(negedge clk);
    chk(sdo === 1'b0, "R1", "sdo in reset", 64'(sdo), 64'd0);
    chk(cmd_valid === 1'b0, "R1", "cmd_valid in reset", 64'(cmd_valid), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo === 1'b0 && cmd_valid === 1'b0, "R1", "outputs after reset",
        64'({sdo, cmd_valid}), 64'd0);

    // R2: two distinct write patterns
    fa = mk(1'b0, 5'd9, 2'd3, 14'h2A5C);
    send(24, 64'(fa));
    expect_cmd(fa, "R2");
    chk(low_ok, "R7", "sdo moved during sclk low", 64'(low_ok), 64'd1);
    fb = mk(1'b0, 5'd31, 2'd0, 14'h3FFF);
    send(24, 64'(fb));
    expect_cmd(fb, "R2");

    // R4 then R3: aborted frame, then a clean one
    send(10, 64'(fa[23:14]));
    expect_none("R4");
    fc = mk(1'b0, 5'd1, 2'd2, 14'h0001);
    send(24, 64'(fc));
    expect_cmd(fc, "R3");

    // R5: standalone overrun by six clocks
    fx = mk(1'b0, 5'd18, 2'd1, 14'h15AA);
    send(30, {34'd0, fx, 6'b101101});
    expect_cmd(fx, "R5");
    ok = 1'b1;
    for (int k = 24; k < 30; k++) if (so_bits[29-k] !== so_bits[29-23]) ok = 1'b0;
    chk(ok, "R5", "sdo moved on ignored edges", so_bits, 64'(so_bits[6]));
    chk(low_ok, "R7", "sdo moved during sclk low", 64'(low_ok), 64'd1);

    // R8: readback of channel 0 select 01, then a NOP clocks it out
    fr = 24'h404ABC;
    send(24, 64'(fr));
    expect_cmd(fr, "R8");
    send(24, 64'd0);
    expect_cmd(24'd0, "R2");
    chk(so_bits[23:0] == {fr[23:14], bank_val(5'd0, 2'd1)}, "R8", "readback word",
        64'(so_bits[23:0]), 64'({fr[23:14], bank_val(5'd0, 2'd1)}));
    chk(low_ok, "R7", "sdo moved during sclk low", 64'(low_ok), 64'd1);

    // R8: second readback pattern
    fr = mk(1'b1, 5'd3, 2'd2, 14'h1234);
    send(24, 64'(fr));
    expect_cmd(fr, "R8");
    send(24, 64'd0);
    expect_cmd(24'd0, "R2");
    chk(so_bits[23:0] == {fr[23:14], bank_val(5'd3, 2'd2)}, "R8", "readback word",
        64'(so_bits[23:0]), 64'({fr[23:14], bank_val(5'd3, 2'd2)}));

    // R6: two-device chain, 48 clocks
    chain_en = 1'b1;
    repeat (4) @(negedge clk);
    fx = mk(1'b0, 5'd7, 2'd2, 14'h0F0F);
    fy = mk(1'b0, 5'd22, 2'd1, 14'h3A01);
    send(48, {16'd0, fx, fy});
    expect_cmd(fy, "R6");
    ok = 1'b1;
    for (int k = 24; k < 48; k++) if (so_bits[47-k] !== fx[47-k]) ok = 1'b0;
    chk(ok, "R6", "pass-through bits on sdo", 64'(so_bits[23:0]), 64'(fx));
    chk(low_ok, "R7", "sdo moved during sclk low", 64'(low_ok), 64'd1);
    send(20, 64'(fy[23:4]));
    expect_none("R4");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule